// File: doc/BRIEF.md
# Bipolar Line-Code Transmit Encoder

This block turns the transmit data of one E1 channel into a pair of registered pulse strobes, one for a positive mark and one for a negative mark, with one decision per bit period. A downstream waveform shaper consumes the strobes. The input can be a single NRZ stream, encoded with either alternate mark inversion (AMI) or HDB3. It can also be a pair of rails that already say which pulse to send, in which case the block passes the pair through.

Both data pins are sampled on the falling edge of the transmit clock. The second pin, `td_aux`, has two roles. In dual-rail operation it is the negative rail. In register-selected single-rail operation with AMI it is a test input: each rising edge forces the next mark to repeat the polarity of the previous pulse, which makes a deliberate bipolar violation.

Single-rail operation can also be entered without software. Holding `td_aux` high for long enough switches the channel into a pin-selected single-rail mode, in which violation insertion is not available. Every path, including dual-rail pass-through, has the same latency, so a change of mode never reorders bits.

Top module: `bipolar_tx_encoder`

## Requirements
- R1: While reset is asserted both strobes are low. After reset is released, the strobes stay low until the first sampled bit emerges, and `line_pos` and `line_neg` are never high together.
- R2: In dual-rail mode the sampled pair (`td_data`, `td_aux`) maps as follows: (1,0) gives a positive pulse, (0,1) gives a negative pulse, and (0,0) or (1,1) gives a space. Every mode delivers the result of a sample on the strobes after the fourth falling edge, counting the sampling edge as the first.
- R3: In AMI single-rail mode a 0 gives a space and each 1 gives a pulse of the opposite polarity to the previous pulse. The first mark after reset is positive.
- R4: When `td_aux` has been sampled high on 17 consecutive falling edges (more than `HOLD_CYCLES` = 16), the channel is in pin-selected single-rail mode from the next sample on, whatever the register bits say. `td_data` is then encoded with the code chosen by `cfg_hdb3`.
- R5: The high-sample counter saturates and clears on any sample with `td_aux` low. A run of 16 highs followed by a low leaves the channel in dual-rail mode. The sample on which `td_aux` is first low is still encoded in pin-selected single-rail mode, and the sample after it is back in register-selected operation.
- R6: Register-selected single-rail mode is active only when both `cfg_mode_en` and `cfg_single` are 1 and the pin rule of R4 does not hold. With either bit at 0 the channel is in dual-rail mode.
- R7: In HDB3 mode (`cfg_hdb3` = 1) every run of four zeros is replaced. The replacement is 000V when an odd number of marks has been sent since the last V, and B00V when that number is even. B alternates like a normal mark and V repeats the polarity of the pulse before it. The count is even, at zero, after reset.
- R8: In register-selected single-rail AMI mode, a rising edge of `td_aux` (low on one sample, high on the next) arms a request. The first mark sampled from that edge on repeats the previous pulse's polarity. The request survives intervening zeros, one request affects one mark, and the alternation resumes from the repeated polarity.
- R9: In register-selected single-rail HDB3 mode, edges on `td_aux` have no effect: the strobes carry the plain HDB3 encoding of `td_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit bit clock; all inputs are sampled and all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode_en | input | 1 | Register bit enabling the register-selected single-rail mode |
| cfg_single | input | 1 | Register bit choosing single rail over dual rail |
| cfg_hdb3 | input | 1 | Line code for single rail: 1 selects HDB3, 0 selects AMI |
| td_data | input | 1 | NRZ data in single rail, positive rail in dual rail, active high |
| td_aux | input | 1 | Negative rail in dual rail, violation-request input in single rail, active high |
| line_pos | output | 1 | Registered positive-pulse strobe for the current bit period |
| line_neg | output | 1 | Registered negative-pulse strobe for the current bit period |

## Verification
A sample taken on falling edge k reaches `line_pos`/`line_neg` at falling edge k+3, because it passes three window stages and then the output register; the encoder needs that window of four bits to recognise an HDB3 zero run. The bench drives input j on rising edge j and compares the strobes on rising edge j+4, half a period after they settle. Mode changes act on whole samples: the pin rule takes effect on the sample after the 17th high, and a low sample clears it only from the sample after that low one. The expected streams model these boundaries explicitly, so each mode switch is checked at the exact bit where it lands.

// File: rtl/bptx_pkg.sv
package bptx_pkg;

    // Operating mode of the channel's system-side interface.
    typedef enum logic [1:0] {
        MODE_DUAL = 2'd0,
        MODE_SR1  = 2'd1,   // single rail, entered by holding the aux pin high
        MODE_SR2  = 2'd2    // single rail, entered through the register bits
    } mode_e;

    // Per-bit symbol travelling through the encoding window.
    // SYM_IDLE must stay at code 0: reset fills the window with it and it
    // is never mistaken for a data zero by the HDB3 run detector.
    typedef enum logic [2:0] {
        SYM_IDLE = 3'd0,   // no pulse, not a single-rail data zero
        SYM_ZERO = 3'd1,   // single-rail data zero
        SYM_MARK = 3'd2,   // pulse that alternates polarity
        SYM_VIOL = 3'd3,   // pulse repeating the previous polarity
        SYM_POS  = 3'd4,   // dual rail: positive pulse
        SYM_NEG  = 3'd5    // dual rail: negative pulse
    } sym_e;

    // Zero run replaced by HDB3 and the window depth it implies.
    localparam int unsigned RUN_LEN   = 4;
    localparam int unsigned WIN_DEPTH = RUN_LEN - 1;

endpackage

// File: rtl/bptx_mode_ctl.sv
module bptx_mode_ctl
    import bptx_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  aux_i,
    input  logic  cfg_en_i,
    input  logic  cfg_single_i,
    output mode_e mode_o
);
    localparam int unsigned CNT_MAX = HOLD_CYCLES + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    // Count consecutive high samples of the aux pin, saturating.
    always_comb begin
        st_d = st_q;
        if (!aux_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_W'(CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Pin rule has priority over the register selection.
    always_comb begin
        if (st_q.cnt == CNT_W'(CNT_MAX))       mode_o = MODE_SR1;
        else if (cfg_en_i && cfg_single_i)     mode_o = MODE_SR2;
        else                                   mode_o = MODE_DUAL;
    end

    // R4: the 17th consecutive high sample switches the next sample to SR1.
    p_sr1_entry_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (aux_i && st_q.cnt == CNT_W'(HOLD_CYCLES)) |=> (mode_o == MODE_SR1));

    // R5: one low sample ends the pin-selected mode for the next sample.
    p_low_exit_r5: assert property (@(negedge clk) disable iff (!rst_n)
        !aux_i |=> (mode_o != MODE_SR1));

endmodule

// File: rtl/bptx_symbolizer.sv
module bptx_symbolizer
    import bptx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode_i,
    input  logic  hdb3_i,
    input  logic  data_i,
    input  logic  aux_i,
    output sym_e  sym_o
);
    typedef struct packed {
        logic aux_prev;   // aux pin on the previous sample
        logic bpv_pend;   // violation request waiting for a mark
    } st_t;

    st_t  st_d, st_q;
    logic aux_rise;
    logic bpv_allowed;
    logic bpv_req;

    always_comb begin
        st_d          = st_q;
        st_d.aux_prev = aux_i;
        st_d.bpv_pend = 1'b0;
        aux_rise      = aux_i && !st_q.aux_prev;
        bpv_allowed   = (mode_i == MODE_SR2) && !hdb3_i;
        bpv_req       = bpv_allowed && (st_q.bpv_pend || aux_rise);
        sym_o         = SYM_IDLE;
        unique case (mode_i)
            MODE_DUAL: begin
                if (data_i == aux_i) sym_o = SYM_IDLE;
                else if (data_i)     sym_o = SYM_POS;
                else                 sym_o = SYM_NEG;
            end
            default: begin
                if (data_i) begin
                    sym_o = bpv_req ? SYM_VIOL : SYM_MARK;
                end else begin
                    sym_o         = SYM_ZERO;
                    st_d.bpv_pend = bpv_req;
                end
            end
        endcase
    end

    // aux_prev resets high so a pin already high at reset is not an edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{aux_prev: 1'b1, bpv_pend: 1'b0};
        else        st_q <= st_d;
    end

    // R9: no pending violation survives a sample outside SR2 with AMI.
    p_no_pend_hdb3_r9: assert property (@(negedge clk) disable iff (!rst_n)
        !bpv_allowed |=> !st_q.bpv_pend);

endmodule

// File: rtl/bptx_pulse_pipe.sv
module bptx_pulse_pipe
    import bptx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sym_e sym_i,
    input  logic hdb3_act_i,
    output logic pos_o,
    output logic neg_o
);
    typedef struct packed {
        sym_e [WIN_DEPTH-1:0] win;   // [0] youngest, [WIN_DEPTH-1] oldest
        logic                 last_pos;
        logic                 odd_marks;
        logic                 pos;
        logic                 neg;
    } st_t;

    st_t  st_d, st_q;
    logic run_hit;
    sym_e in_sym;
    sym_e out_sym;

    always_comb begin
        st_d = st_q;

        // Four plain zeros: the incoming one plus the whole window.
        run_hit = hdb3_act_i && (sym_i == SYM_ZERO);
        for (int k = 0; k < WIN_DEPTH; k++) begin
            if (st_q.win[k] != SYM_ZERO) run_hit = 1'b0;
        end

        in_sym  = sym_i;
        out_sym = st_q.win[WIN_DEPTH-1];
        if (run_hit) begin
            in_sym = SYM_VIOL;
            if (!st_q.odd_marks) out_sym = SYM_MARK;   // B00V
        end

        st_d.win[0] = in_sym;
        for (int k = 1; k < WIN_DEPTH; k++) begin
            st_d.win[k] = st_q.win[k-1];
        end

        st_d.pos = 1'b0;
        st_d.neg = 1'b0;
        case (out_sym)
            SYM_MARK: begin
                st_d.pos       = !st_q.last_pos;
                st_d.neg       = st_q.last_pos;
                st_d.last_pos  = !st_q.last_pos;
                st_d.odd_marks = !st_q.odd_marks;
            end
            SYM_VIOL: begin
                st_d.pos       = st_q.last_pos;
                st_d.neg       = !st_q.last_pos;
                st_d.odd_marks = 1'b0;
            end
            SYM_POS: st_d.pos = 1'b1;
            SYM_NEG: st_d.neg = 1'b1;
            default: ;
        endcase
    end

    // All-zero reset: window full of SYM_IDLE, last pulse taken as negative.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o = st_q.pos;
    assign neg_o = st_q.neg;

    // R1: the two strobes are mutually exclusive.
    p_strobe_excl_r1: assert property (@(negedge clk) disable iff (!rst_n)
        $onehot0({st_q.pos, st_q.neg}));

    // R7: a substitution V enters the window as soon as a zero run is seen.
    p_run_replaced_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (hdb3_act_i && sym_i == SYM_ZERO && st_q.win == {WIN_DEPTH{SYM_ZERO}})
        |=> (st_q.win[0] == SYM_VIOL));

endmodule

// File: rtl/bipolar_tx_encoder.sv
module bipolar_tx_encoder
    import bptx_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic tx_clk,
    input  logic rst_n,
    input  logic cfg_mode_en,
    input  logic cfg_single,
    input  logic cfg_hdb3,
    input  logic td_data,
    input  logic td_aux,
    output logic line_pos,
    output logic line_neg
);
    mode_e mode;
    sym_e  sym;
    logic  hdb3_act;

    bptx_mode_ctl #(.HOLD_CYCLES(HOLD_CYCLES)) u_mode (
        .clk          (tx_clk),
        .rst_n        (rst_n),
        .aux_i        (td_aux),
        .cfg_en_i     (cfg_mode_en),
        .cfg_single_i (cfg_single),
        .mode_o       (mode)
    );

    bptx_symbolizer u_sym (
        .clk    (tx_clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .hdb3_i (cfg_hdb3),
        .data_i (td_data),
        .aux_i  (td_aux),
        .sym_o  (sym)
    );

    assign hdb3_act = (mode != MODE_DUAL) && cfg_hdb3;

    bptx_pulse_pipe u_pipe (
        .clk        (tx_clk),
        .rst_n      (rst_n),
        .sym_i      (sym),
        .hdb3_act_i (hdb3_act),
        .pos_o      (line_pos),
        .neg_o      (line_neg)
    );

    // Edges seen since reset, saturating; arms the latency check below.
    logic [2:0] warm_q;
    always_ff @(negedge tx_clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 3'd4) warm_q <= warm_q + 3'd1;
    end

    // R2: a dual-rail (1,0) sample shows as a positive pulse four edges later.
    p_dual_map_r2: assert property (@(negedge tx_clk) disable iff (!rst_n || warm_q != 3'd4)
        ($past(mode, 4) == MODE_DUAL && $past(td_data, 4) && !$past(td_aux, 4))
        |-> (line_pos && !line_neg));

endmodule

// File: tb/bipolar_tx_encoder_test.sv
module bipolar_tx_encoder_test;

    localparam int MAXL = 2200;

    logic clk;
    logic rst_n;
    logic cfg_mode_en, cfg_single, cfg_hdb3;
    logic td_data, td_aux;
    logic line_pos, line_neg;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    logic  sp   [MAXL];
    logic  sn   [MAXL];
    logic  ep   [MAXL];
    logic  en   [MAXL];
    logic  frc  [MAXL];
    int    kind [MAXL];
    string tag  [MAXL];

    bipolar_tx_encoder uut (
        .tx_clk      (clk),
        .rst_n       (rst_n),
        .cfg_mode_en (cfg_mode_en),
        .cfg_single  (cfg_single),
        .cfg_hdb3    (cfg_hdb3),
        .td_data     (td_data),
        .td_aux      (td_aux),
        .line_pos    (line_pos),
        .line_neg    (line_neg)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input logic ap, input logic an, input logic xp,
                       input logic xn, input string t);
        vectors++;
        if (ap !== xp || an !== xn) begin
            fails++;
            $display("FAIL %s: actual pos/neg=%b%b expected=%b%b", t, ap, an, xp, xn);
        end
    endtask

    task automatic do_reset(input logic m_en, input logic m_single, input logic m_hdb3);
        rst_n = 1'b0;
        cfg_mode_en = m_en; cfg_single = m_single; cfg_hdb3 = m_hdb3;
        td_data = 1'b0; td_aux = 1'b0;
        repeat (3) @(posedge clk);
        chk(line_pos, line_neg, 1'b0, 1'b0, "R1 strobes low in reset");
        rst_n = 1'b1;
    endtask

    // Input j is driven on rising edge j; its pulse is compared on edge j+4.
    task automatic run_stream(input int L);
        for (int j = 0; j <= L; j++) begin
            if (j >= 4) chk(line_pos, line_neg, ep[j-4], en[j-4], tag[j-4]);
            else        chk(line_pos, line_neg, 1'b0, 1'b0, "R1 idle after reset");
            if (j < L) begin
                td_data = sp[j];
                td_aux  = sn[j];
            end
            @(posedge clk);
        end
    endtask

    function automatic void fill_dual(input int off, input int L, input string t);
        for (int i = off; i < off + L; i++) begin
            ep[i]  = sp[i] & ~sn[i];
            en[i]  = sn[i] & ~sp[i];
            tag[i] = t;
        end
    endfunction

    function automatic void calc_force(input int L);
        logic prev = 1'b1;
        logic pend = 1'b0;
        for (int i = 0; i < L; i++) begin
            logic req;
            req  = pend | (sn[i] & ~prev);
            prev = sn[i];
            if (sp[i]) begin frc[i] = req;  pend = 1'b0; end
            else       begin frc[i] = 1'b0; pend = req;  end
        end
    endfunction

    function automatic void fill_ami(input int off, input int L, input logic use_frc,
                                     input string t);
        logic lp = 1'b0;
        for (int i = off; i < off + L; i++) begin
            if (sp[i]) begin
                if (!(use_frc && frc[i])) lp = ~lp;
                ep[i] = lp; en[i] = ~lp;
            end else begin
                ep[i] = 1'b0; en[i] = 1'b0;
            end
            tag[i] = t;
        end
    endfunction

    // kind: 0 space, 1 alternating mark, 2 violation
    function automatic void fill_hdb3(input int off, input int L, input string t);
        logic lp  = 1'b0;
        logic odd = 1'b0;
        for (int i = off; i < off + L; i++) kind[i] = sp[i] ? 1 : 0;
        for (int i = off; i < off + L; i++) begin
            if (i + 3 < off + L && kind[i] == 0 && kind[i+1] == 0 &&
                kind[i+2] == 0 && kind[i+3] == 0) begin
                kind[i+3] = 2;
                kind[i]   = odd ? 0 : 1;
            end
            ep[i] = 1'b0; en[i] = 1'b0;
            if (kind[i] == 1) begin
                lp = ~lp; odd = ~odd;
                ep[i] = lp; en[i] = ~lp;
            end else if (kind[i] == 2) begin
                odd = 1'b0;
                ep[i] = lp; en[i] = ~lp;
            end
            tag[i] = t;
        end
    endfunction

    function automatic logic count_bit(input int i);
        int v = (i / 8) % 256;
        return logic'((v >> (i % 8)) & 1);
    endfunction

    task automatic sr1_run(input logic hdb3);
        int L;
        do_reset(1'b0, 1'b0, hdb3);
        for (int i = 0; i < 17; i++) begin sp[i] = 1'b0; sn[i] = 1'b1; end
        fill_dual(0, 17, "R4 dual before hold expires");
        for (int i = 17; i < 217; i++) begin
            sp[i] = (i == 17) ? 1'b1 : count_bit(i * 3 + 1);
            sn[i] = 1'b1;
        end
        sp[217] = 1'b0; sn[217] = 1'b0;
        if (hdb3) fill_hdb3(17, 201, "R4 pin-selected HDB3");
        else      fill_ami(17, 201, 1'b0, "R4 pin-selected AMI");
        tag[217] = "R5 low sample still single rail";
        for (int i = 218; i < 226; i++) begin
            sp[i] = logic'((i >> 1) & 1);
            sn[i] = logic'(i & 1);
        end
        fill_dual(218, 8, "R5 dual after low sample");
        L = 226;
        run_stream(L);
    endtask

    initial begin
        // R2 dual-rail mapping over all pairs, in several register settings (R6)
        for (int i = 0; i < 68; i++) begin
            int v = (i + i / 4) % 4;
            sp[i] = logic'(v >> 1);
            sn[i] = logic'(v & 1);
        end
        fill_dual(0, 68, "R2 dual map");
        do_reset(1'b0, 1'b0, 1'b0);
        run_stream(68);
        for (int i = 0; i < 68; i++) tag[i] = "R6 single bit without enable";
        do_reset(1'b0, 1'b1, 1'b0);
        run_stream(68);
        for (int i = 0; i < 68; i++) tag[i] = "R6 enable without single bit";
        do_reset(1'b1, 1'b0, 1'b1);
        run_stream(68);

        // R3 AMI over every byte value
        for (int i = 0; i < 2056; i++) begin sp[i] = count_bit(i); sn[i] = 1'b0; end
        fill_ami(0, 2056, 1'b0, "R3 AMI alternation");
        do_reset(1'b1, 1'b1, 1'b0);
        run_stream(2056);

        // R7 HDB3 over every byte value
        fill_hdb3(0, 2056, "R7 HDB3 substitution");
        do_reset(1'b1, 1'b1, 1'b1);
        run_stream(2056);

        // R8 violation requests in AMI, R9 same stimulus in HDB3
        for (int i = 0; i < 600; i++) begin
            sp[i] = count_bit(i + 40);
            sn[i] = logic'((i % 23) < 2);
        end
        calc_force(600);
        fill_ami(0, 600, 1'b1, "R8 forced violation");
        do_reset(1'b1, 1'b1, 1'b0);
        run_stream(600);
        fill_hdb3(0, 600, "R9 requests ignored in HDB3");
        do_reset(1'b1, 1'b1, 1'b1);
        run_stream(600);

        // R4 pin-selected mode with both codes, R5 exit
        sr1_run(1'b0);
        sr1_run(1'b1);

        // R5 16 highs are not enough, and a low sample restarts the count
        for (int i = 0; i < 16; i++) begin sp[i] = 1'b0; sn[i] = 1'b1; end
        sp[16] = 1'b1; sn[16] = 1'b0;
        for (int i = 17; i < 23; i++) begin sp[i] = 1'b0; sn[i] = 1'b1; end
        sp[23] = 1'b1; sn[23] = 1'b1;
        for (int i = 24; i < 28; i++) begin sp[i] = 1'b1; sn[i] = 1'b0; end
        fill_dual(0, 28, "R5 counter clear below threshold");
        do_reset(1'b0, 1'b0, 1'b1);
        run_stream(28);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule